// File: doc/BRIEF.md
# Back-EMF Sample-Hold Sequencer

This block generates the control signals for an analog back-EMF monitor path on a two-phase stepper driver. The coil voltage can only be observed while a coil's current setpoint is zero. There are two such intervals per coil in each electrical period, so four per period in total. The sequencer watches a per-coil zero-setpoint flag. From it, the block chooses which coil the analog path looks at, and when the analog switch tracks the coil voltage or holds its last sample.

A mode bit selects between two behaviours:

- **Transparent mode.** The track switch stays closed for the whole zero-current interval, so the output shows the full decay transient.
- **Sampled mode.** The track switch stays open. A single-cycle sample strobe is issued when the interval ends, which is the next step trigger. The strobe is only issued if the coil current has finished decaying within that interval. The held value therefore changes once per interval, and only to a settled reading.

A gain bit is passed through as a registered divider select for the analog scaler.

Top module: `bemf_sh_seq`

## Requirements
- R1: While `rst_n` is low, `track_o`, `strobe_o`, `coil_sel_o` and `div4_o` are all 0.
- R2: One clock after any bit of `zero_i` is high, `coil_sel_o` equals the index of the lowest-numbered coil whose zero flag is high (coil X = bit 0 gives 0, coil Y = bit 1 gives 1).
- R3: One clock after a cycle with no zero flag set, `coil_sel_o` keeps its previous value.
- R4: With `transp_i` = 1, `track_o` is 1 exactly one clock after a cycle in which any zero flag is high, whether or not decay has finished, and `strobe_o` stays 0.
- R5: With `transp_i` = 0, `track_o` is 0.
- R6: With `transp_i` = 0, `strobe_o` is high for one clock, one clock after a cycle in which `step_i` is high while a zero flag is high, provided `decay_done_i` was seen high in that same observation window (earlier or in the step cycle itself).
- R7: A step that ends a window in which `decay_done_i` was never high produces no strobe. A decay indication from an earlier window, or from before a previous step, does not count.
- R8: A step while no zero flag is high produces no strobe.
- R9: `div4_o` equals the `gain_i` value of the previous clock: 0 selects divide-by-2, and 1 selects divide-by-4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zero_i | input | 2 | Per-coil zero-setpoint flags (bit 0 coil X, bit 1 coil Y) |
| step_i | input | 1 | Step trigger pulse, ends the current zero interval |
| decay_done_i | input | 1 | Coil current has decayed to zero |
| transp_i | input | 1 | 1 = transparent tracking, 0 = sample at end of interval |
| gain_i | input | 1 | Divider choice: 0 = divide by 2, 1 = divide by 4 |
| track_o | output | 1 | Analog switch closed (output follows coil voltage) |
| strobe_o | output | 1 | One-clock sample-and-hold update pulse |
| coil_sel_o | output | 1 | Index of the coil being observed |
| div4_o | output | 1 | Divider select for the analog scaler |

## Verification
The bench covers several corner cases, each tied to a specific design error:

- **Decay arriving in the step cycle.** Decay is flagged in the same cycle as the step. A design that only consulted the registered decay flag would drop this strobe.
- **Decay from a window that closed without a step.** The flag must not carry into the next window. A design that forgot to clear it would issue a strobe carrying a transient value.
- **Steps outside any window.** These must produce no strobe.
- **Both coils flagged at once.** Coil X must win the priority.
- **Gaps between windows.** The coil select must hold. A design that reset it would make the analog path jump coils.
- **Transparent mode before decay.** Tracking must already be closed at that point. A design gating tracking on decay would hide the transient this mode exists to show.

// File: rtl/bemf_sh_pkg.sv
package bemf_sh_pkg;

    // Registered output bundle of the sequencer top
    typedef struct packed {
        logic track;
        logic strobe;
        logic div4;
    } seq_out_t;

    localparam seq_out_t SEQ_OUT_RST = '{track: 1'b0, strobe: 1'b0, div4: 1'b0};

endpackage

// File: rtl/bemf_coil_tracker.sv
module bemf_coil_tracker #(
    parameter int COIL_N = 2,
    parameter int COIL_W = (COIL_N > 1) ? $clog2(COIL_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COIL_N-1:0] zero_i,
    output logic              win_o,
    output logic [COIL_W-1:0] coil_o
);

    logic [COIL_W-1:0] coil_d, coil_q;
    logic              found;

    always_comb begin
        coil_d = coil_q;
        found  = 1'b0;
        for (int i = 0; i < COIL_N; i++) begin
            if (zero_i[i] && !found) begin
                coil_d = COIL_W'(i);
                found  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coil_q <= '0;
        else        coil_q <= coil_d;
    end

    assign win_o  = |zero_i;
    assign coil_o = coil_q;

endmodule

// File: rtl/bemf_decay_tracker.sv
module bemf_decay_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic win_i,
    input  logic step_i,
    input  logic decay_i,
    output logic settled_o
);

    logic seen_d, seen_q;

    // settled now: either seen earlier in this window or flagged this cycle
    assign settled_o = seen_q | decay_i;

    always_comb begin
        // a step or a closed window starts a fresh observation
        seen_d = win_i & ~step_i & settled_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

endmodule

// File: rtl/bemf_sh_seq.sv
module bemf_sh_seq
    import bemf_sh_pkg::*;
#(
    parameter int COIL_N = 2,
    localparam int COIL_W = (COIL_N > 1) ? $clog2(COIL_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COIL_N-1:0] zero_i,
    input  logic              step_i,
    input  logic              decay_done_i,
    input  logic              transp_i,
    input  logic              gain_i,
    output logic              track_o,
    output logic              strobe_o,
    output logic [COIL_W-1:0] coil_sel_o,
    output logic              div4_o
);

    logic     win;
    logic     settled;
    seq_out_t out_d, out_q;

    bemf_coil_tracker #(.COIL_N(COIL_N), .COIL_W(COIL_W)) coil_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .zero_i (zero_i),
        .win_o  (win),
        .coil_o (coil_sel_o)
    );

    bemf_decay_tracker decay_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_i     (win),
        .step_i    (step_i),
        .decay_i   (decay_done_i),
        .settled_o (settled)
    );

    always_comb begin
        out_d        = out_q;
        out_d.track  = transp_i & win;
        out_d.strobe = ~transp_i & win & step_i & settled;
        out_d.div4   = gain_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= SEQ_OUT_RST;
        else        out_q <= out_d;
    end

    assign track_o  = out_q.track;
    assign strobe_o = out_q.strobe;
    assign div4_o   = out_q.div4;

endmodule

// File: rtl/bemf_sh_seq_chk.sv
module bemf_sh_seq_chk #(
    parameter int COIL_N = 2,
    parameter int COIL_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [COIL_N-1:0] zero_i,
    input logic              step_i,
    input logic              transp_i,
    input logic              gain_i,
    input logic              track_o,
    input logic              strobe_o,
    input logic [COIL_W-1:0] coil_sel_o,
    input logic              div4_o
);

    // R4
    transp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(transp_i) && $past(|zero_i) |-> track_o);

    // R5
    sampled_no_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(transp_i) |-> !track_o);

    // R6
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && strobe_o |-> $past(step_i) && !$past(transp_i));

    // R8
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(zero_i) == '0 |-> !strobe_o);

    // R3
    coil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(zero_i) == '0 |-> $stable(coil_sel_o));

    // R9
    div_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> div4_o == $past(gain_i));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!track_o && !strobe_o && !div4_o);
        end
    end

endmodule

bind bemf_sh_seq bemf_sh_seq_chk #(.COIL_N(COIL_N), .COIL_W(COIL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .zero_i     (zero_i),
    .step_i     (step_i),
    .transp_i   (transp_i),
    .gain_i     (gain_i),
    .track_o    (track_o),
    .strobe_o   (strobe_o),
    .coil_sel_o (coil_sel_o),
    .div4_o     (div4_o)
);

// File: tb/bemf_sh_seq_tb.sv
module bemf_sh_seq_tb_top;

    typedef struct {
        logic track;
        logic strobe;
        logic coil;
        logic div4;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] zero = '0;
    logic       step = 1'b0, decay = 1'b0, transp = 1'b0, gain = 1'b0;
    logic       track, strobe, coil, div4;

    int checks = 0, failures = 0;
    exp_t q[$];

    // reference state from the requirements
    logic seen_m = 1'b0;
    logic coil_m = 1'b0;

    always #4 clk = ~clk;

    bemf_sh_seq dut_i (
        .clk(clk), .rst_n(rst_n), .zero_i(zero), .step_i(step),
        .decay_done_i(decay), .transp_i(transp), .gain_i(gain),
        .track_o(track), .strobe_o(strobe), .coil_sel_o(coil), .div4_o(div4)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // driver: apply one cycle of stimulus and push what must appear after the edge
    task automatic drive(input logic [1:0] z, input logic s, input logic d,
                         input logic t, input logic g, input string tag);
        exp_t e;
        logic win, settled;
        @(negedge clk);
        zero = z; step = s; decay = d; transp = t; gain = g;
        win     = |z;
        settled = seen_m | d;
        e.track  = t & win;                  // R4 / R5
        e.strobe = !t & win & s & settled;   // R6 / R7 / R8
        if (z[0])      coil_m = 1'b0;        // R2
        else if (z[1]) coil_m = 1'b1;        // R3 otherwise holds
        e.coil = coil_m;
        e.div4 = g;                          // R9
        e.tag  = tag;
        seen_m = win & !s & settled;
        q.push_back(e);
    endtask

    // monitor: compare two time units after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " R4_R5 track"}, track, e.track);
                check({e.tag, " R6 strobe"}, strobe, e.strobe);
                check({e.tag, " R2_R3 coil"}, coil, e.coil);
                check({e.tag, " R9 div4"}, div4, e.div4);
            end
        end
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: drive inputs high during reset, outputs must stay zero
        zero = 2'b11; step = 1'b1; decay = 1'b1; gain = 1'b1; transp = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        check("R1 track", track, 1'b0);
        check("R1 strobe", strobe, 1'b0);
        check("R1 coil", coil, 1'b0);
        check("R1 div4", div4, 1'b0);
        @(negedge clk);
        zero = '0; step = 0; decay = 0; gain = 0; transp = 0;
        rst_n = 1'b1;

        // R6: coil X window, decay mid-window, step ends it -> strobe
        drive(2'b01, 0, 0, 0, 0, "R6a");
        drive(2'b01, 0, 1, 0, 0, "R6a");
        drive(2'b01, 0, 0, 0, 0, "R6a");
        drive(2'b01, 1, 0, 0, 0, "R6a");
        drive(2'b00, 0, 0, 0, 0, "R6a");

        // R6: coil Y window, decay in the step cycle itself
        drive(2'b10, 0, 0, 0, 1, "R6b");
        drive(2'b10, 1, 1, 0, 1, "R6b");
        drive(2'b00, 0, 0, 0, 0, "R3");
        drive(2'b00, 0, 0, 0, 1, "R3");

        // R7: step before decay -> no strobe
        drive(2'b01, 0, 0, 0, 0, "R7a");
        drive(2'b01, 1, 0, 0, 0, "R7a");
        // R7: decay seen before the step ends its window, next step needs fresh decay
        drive(2'b01, 0, 1, 0, 0, "R7b");
        drive(2'b01, 1, 1, 0, 0, "R7b");
        drive(2'b01, 1, 0, 0, 0, "R7b");
        // R7: decay, window closes without step, reopens, step -> none
        drive(2'b10, 0, 1, 0, 0, "R7c");
        drive(2'b00, 0, 0, 0, 0, "R7c");
        drive(2'b10, 0, 0, 0, 0, "R7c");
        drive(2'b10, 1, 0, 0, 0, "R7c");

        // R8: step outside any window, decay high -> none, coil holds (R3)
        drive(2'b00, 1, 1, 0, 1, "R8");
        drive(2'b00, 1, 0, 0, 0, "R8");

        // R2: both flagged -> coil X wins
        drive(2'b11, 0, 1, 0, 0, "R2");
        drive(2'b11, 1, 0, 0, 0, "R2");

        // R4: transparent mode tracks before decay, no strobe on step
        drive(2'b10, 0, 0, 1, 1, "R4");
        drive(2'b10, 0, 1, 1, 1, "R4");
        drive(2'b10, 1, 0, 1, 0, "R4");
        drive(2'b00, 0, 0, 1, 0, "R4");
        // R5: switch back to sampled mode mid-window
        drive(2'b01, 0, 1, 1, 0, "R5");
        drive(2'b01, 0, 0, 0, 0, "R5");
        drive(2'b01, 1, 0, 0, 1, "R5");
        drive(2'b00, 0, 0, 0, 1, "R9");
        drive(2'b00, 0, 0, 0, 0, "R9");

        while (q.size() != 0) @(posedge clk);
        #4;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule